// File: doc/BRIEF.md
# Indirect-Target Label Guard

This block sits beside an in-order instruction stream (the decode stage, or the retire stage) and checks that every indirect call or jump lands on a target-marker instruction carrying the same label. It sees at most one instruction per cycle, qualified by a valid bit. An indirect branch arms the guard and stores its label. The next valid instruction is the one checked. If that instruction is not a marker, or is a marker whose label differs from the stored one, the guard flags it in the same cycle as it is presented.

A parameter picks where the guard sits. In the decode placement a failure raises a request to inject a load-fence micro-op ahead of the offending instruction. In the retire placement the same failure raises a control-flow violation instead. A second parameter selects a coarse mode in which labels are ignored, so only the presence of a marker is checked. A pipeline flush disarms the guard.

Instruction kinds are given on a 2-bit field. The code `01` is an indirect call or jump, `10` is a target marker, and `00` or `11` is any other instruction.

Top module: `cfi_target_guard`

## Requirements
- R1: A valid indirect branch (kind `01`) that is not flushed arms the guard and stores its `in_label`. The next valid instruction is the one checked.
- R2: While armed, a valid marker (kind `10`) whose label equals the stored label raises no failure in that cycle and disarms the guard.
- R3: In fine mode, while armed, a valid marker whose label differs from the stored label raises a failure in the same cycle.
- R4: While armed, a valid instruction of kind `00` or `11` raises a failure in the same cycle and disarms the guard.
- R5: While armed, a valid indirect branch fails the check in that cycle. It then re-arms the guard with its own label.
- R6: In the decode placement a failure drives `fence_req`, and `cfi_viol` stays 0. In the retire placement a failure drives `cfi_viol`, and `fence_req` stays 0.
- R7: In coarse mode the label bits are ignored, and any marker satisfies an armed guard.
- R8: `flush` disarms the guard at the next edge. The instruction presented with `flush` raises no failure and does not arm the guard.
- R9: Cycles with `in_valid` low neither change the armed state or the stored label nor raise a failure.
- R10: A marker or any other non-branch instruction seen while the guard is disarmed raises no failure and leaves the guard disarmed.
- R11: After reset the guard is disarmed and both failure outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Pipeline flush; disarms the guard |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_kind | input | 2 | Instruction kind: 01 indirect branch, 10 marker, 00/11 other |
| in_label | input | LBL_W (32) | Label of the branch or marker |
| fence_req | output | 1 | Inject a load fence ahead of the presented instruction (decode placement) |
| cfi_viol | output | 1 | Control-flow violation on the presented instruction (retire placement) |

## Verification
The bench builds two instances side by side. The first uses the decode placement in fine mode with 32-bit labels. The second uses the retire placement in coarse mode. Both receive the same stream, so the same mismatching-marker stimulus must fence on the first and pass on the second. Together they exercise both output routes and both comparator variants. The stream mixes directed sequences with randomized ones drawn from a small label pool. This makes label matches, back-to-back branches, bubbles inside an armed window and flushes coinciding with instructions frequent.

// File: rtl/cfi_guard_pkg.sv
package cfi_guard_pkg;
    typedef enum logic [1:0] {
        K_PLAIN = 2'b00,
        K_INDIR = 2'b01,
        K_MARK  = 2'b10,
        K_RSVD  = 2'b11
    } ikind_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } gst_e;

    localparam int STG_DECODE = 0;
    localparam int STG_COMMIT = 1;
endpackage

// File: rtl/cfi_lbl_cmp.sv
module cfi_lbl_cmp #(
    parameter int LBL_W  = 32,
    parameter bit COARSE = 1'b0
) (
    input  logic [1:0]       in_kind,
    input  logic [LBL_W-1:0] in_label,
    input  logic [LBL_W-1:0] held_lbl,
    output logic             tgt_ok
);
    import cfi_guard_pkg::*;

    logic is_mark;
    assign is_mark = (ikind_e'(in_kind) == K_MARK);

    generate
        if (COARSE) begin : g_coarse
            wire unused_lbl = ^{in_label, held_lbl};
            assign tgt_ok = is_mark;
        end else begin : g_fine
            assign tgt_ok = is_mark && (in_label == held_lbl);
        end
    endgenerate
endmodule

// File: rtl/cfi_arm_fsm.sv
module cfi_arm_fsm #(
    parameter int LBL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    input  logic [1:0]       in_kind,
    input  logic [LBL_W-1:0] in_label,
    input  logic             tgt_ok,
    output logic             armed_o,
    output logic [LBL_W-1:0] lbl_o,
    output logic             fail_o
);
    import cfi_guard_pkg::*;

    typedef struct packed {
        gst_e             st;
        logic [LBL_W-1:0] lbl;
    } gstate_t;

    gstate_t cur_q, nxt_d;
    logic    fail_d;

    always_comb begin
        nxt_d  = cur_q;
        fail_d = 1'b0;
        if (flush) begin
            nxt_d.st  = S_IDLE;
            nxt_d.lbl = '0;
        end else if (in_valid) begin
            if (cur_q.st == S_WAIT && !tgt_ok) begin
                fail_d = 1'b1;
            end
            if (ikind_e'(in_kind) == K_INDIR) begin
                nxt_d.st  = S_WAIT;
                nxt_d.lbl = in_label;
            end else if (cur_q.st == S_WAIT) begin
                nxt_d.st = S_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: S_IDLE, lbl: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign armed_o = (cur_q.st == S_WAIT);
    assign lbl_o   = cur_q.lbl;
    assign fail_o  = fail_d;

    AST_ARM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush && in_kind == 2'b01) |=> (armed_o && lbl_o == $past(in_label))); // R1
    AST_WAIT_RESOLVES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush && armed_o && in_kind != 2'b01) |=> !armed_o); // R4
    AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !armed_o); // R8
    AST_BUBBLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !flush) |=> ($stable(armed_o) && $stable(lbl_o))); // R9
endmodule

// File: rtl/cfi_fail_route.sv
module cfi_fail_route #(
    parameter int STAGE = 0
) (
    input  logic fail_i,
    output logic fence_req,
    output logic cfi_viol
);
    import cfi_guard_pkg::*;

    generate
        if (STAGE == STG_COMMIT) begin : g_commit
            assign fence_req = 1'b0;
            assign cfi_viol  = fail_i;
        end else begin : g_decode
            assign fence_req = fail_i;
            assign cfi_viol  = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/cfi_target_guard.sv
module cfi_target_guard #(
    parameter int LBL_W  = 32,
    parameter bit COARSE = 1'b0,
    parameter int STAGE  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    input  logic [1:0]       in_kind,
    input  logic [LBL_W-1:0] in_label,
    output logic             fence_req,
    output logic             cfi_viol
);
    logic             tgt_ok;
    logic             armed;
    logic [LBL_W-1:0] held_lbl;
    logic             fail;

    cfi_lbl_cmp #(.LBL_W(LBL_W), .COARSE(COARSE)) u_cmp (
        .in_kind  (in_kind),
        .in_label (in_label),
        .held_lbl (held_lbl),
        .tgt_ok   (tgt_ok)
    );

    cfi_arm_fsm #(.LBL_W(LBL_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .in_valid (in_valid),
        .in_kind  (in_kind),
        .in_label (in_label),
        .tgt_ok   (tgt_ok),
        .armed_o  (armed),
        .lbl_o    (held_lbl),
        .fail_o   (fail)
    );

    cfi_fail_route #(.STAGE(STAGE)) u_route (
        .fail_i    (fail),
        .fence_req (fence_req),
        .cfi_viol  (cfi_viol)
    );

    AST_SINGLE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        !(fence_req && cfi_viol)); // R6
    AST_MATCH_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && in_valid && !flush && in_kind == 2'b10 && in_label == held_lbl)
            |-> !(fence_req || cfi_viol)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && in_valid && in_kind != 2'b01) |=> !armed); // R10
endmodule

// File: tb/sim_cfi_target_guard.sv
module sim_cfi_target_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_kind = 2'b00;
    logic [31:0] in_label = '0;
    logic        f0, v0, f1, v1;

    int tests = 0;
    int fails = 0;

    // reference state: fine/decode (m0) and coarse/commit (m1)
    bit          m0_arm = 0, m1_arm = 0;
    logic [31:0] m0_lbl = '0, m1_lbl = '0;

    always #2.5 clk = ~clk;

    cfi_target_guard #(.LBL_W(32), .COARSE(1'b0), .STAGE(0)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_kind(in_kind), .in_label(in_label), .fence_req(f0), .cfi_viol(v0));

    cfi_target_guard #(.LBL_W(32), .COARSE(1'b1), .STAGE(1)) u1 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_kind(in_kind), .in_label(in_label), .fence_req(f1), .cfi_viol(v1));

    task automatic chk(input logic act, input logic exp, input string what, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b @%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit expect_fail(bit arm, logic [31:0] lbl, bit coarse,
                                       bit fl, bit v, logic [1:0] k, logic [31:0] lb);
        if (fl || !v || !arm) return 1'b0;
        return !(k == 2'b10 && (coarse || lbl == lb));
    endfunction

    task automatic model_upd(inout bit arm, inout logic [31:0] lbl,
                             input bit fl, input bit v, input logic [1:0] k, input logic [31:0] lb);
        if (fl) begin arm = 0; lbl = '0; end
        else if (v) begin
            if (k == 2'b01) begin arm = 1; lbl = lb; end
            else arm = 0;
        end
    endtask

    task automatic step(input bit fl, input bit v, input logic [1:0] k,
                        input logic [31:0] lb, input string tag);
        bit e0, e1;
        @(negedge clk);
        flush = fl; in_valid = v; in_kind = k; in_label = lb;
        #1;
        e0 = expect_fail(m0_arm, m0_lbl, 1'b0, fl, v, k, lb);
        e1 = expect_fail(m1_arm, m1_lbl, 1'b1, fl, v, k, lb);
        chk(f0, e0, "fine fence_req", tag);
        chk(v0, 1'b0, "fine cfi_viol (R6)", tag);
        chk(v1, e1, "coarse cfi_viol (R6)", tag);
        chk(f1, 1'b0, "coarse fence_req (R6)", tag);
        model_upd(m0_arm, m0_lbl, fl, v, k, lb);
        model_upd(m1_arm, m1_lbl, fl, v, k, lb);
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(f0, 1'b0, "reset fence_req", "R11");
        chk(v1, 1'b0, "reset cfi_viol", "R11");
        @(negedge clk); rst_n = 1'b1;
        step(0, 1, 2'b00, 32'h0, "R11");
        step(0, 1, 2'b10, 32'h5, "R10");
        step(0, 1, 2'b11, 32'h5, "R10");
        step(0, 1, 2'b01, 32'h1234, "R1");
        step(0, 1, 2'b10, 32'h1234, "R2");
        step(0, 1, 2'b00, 32'h0, "R2");
        step(0, 1, 2'b01, 32'hAAAA_0001, "R1");
        step(0, 1, 2'b10, 32'hAAAA_0002, "R3 R7");
        step(0, 1, 2'b10, 32'hAAAA_0001, "R10");
        step(0, 1, 2'b01, 32'h77, "R1");
        step(0, 1, 2'b00, 32'h77, "R4");
        step(0, 1, 2'b00, 32'h77, "R4");
        step(0, 1, 2'b01, 32'h88, "R1");
        step(0, 1, 2'b11, 32'h88, "R4");
        step(0, 1, 2'b01, 32'h99, "R1");
        step(0, 0, 2'b00, 32'h0, "R9");
        step(0, 0, 2'b10, 32'h1, "R9");
        step(0, 0, 2'b01, 32'h2, "R9");
        step(0, 1, 2'b10, 32'h99, "R9");
        step(0, 1, 2'b01, 32'h42, "R1");
        step(1, 1, 2'b00, 32'h0, "R8");
        step(0, 1, 2'b00, 32'h0, "R8");
        step(1, 1, 2'b01, 32'h43, "R8");
        step(0, 1, 2'b10, 32'h43, "R8");
        step(0, 1, 2'b01, 32'h10, "R1");
        step(0, 1, 2'b01, 32'h20, "R5");
        step(0, 1, 2'b10, 32'h20, "R5");
        step(0, 1, 2'b01, 32'h30, "R1");
        step(0, 1, 2'b01, 32'h31, "R5");
        step(0, 1, 2'b10, 32'h30, "R5 R7");
        for (int i = 0; i < 2000; i++) begin
            step(($urandom % 16) == 0, ($urandom % 5) != 0, 2'($urandom),
                 32'($urandom % 3), "R3");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule